// File: doc/BRIEF.md
# T1 Receive Alarm Detector

This block watches a recovered T1 receive bit stream and derives the three line alarms: the all-ones indication (AIS, blue), the remote alarm (RAI, yellow) and loss of signal (RLOS, red). Each bit arrives with a valid strobe. The framer also supplies per-bit markers. These flag a channel's bit 2, the F-bit of the 12th frame, and a facility data link (FDL) bit. The block does not find frame alignment itself. It relies on those markers. It does gather FDL bits into 16-bit words internally.

Every alarm has a set rule and a separate, weaker clear rule, so a marginal line does not make the status chatter. Each status output is a level that holds until its clear rule is met. The yellow alarm has three detectors that run side by side. Two mode pins choose which one drives the output. The bit input is a valid/ready stream. `bit_ready` is always high, so the block never applies back-pressure. A bit and its markers are taken on every clock edge where `bit_valid` is high.

Top module: `t1_rx_alarm_det`

## Requirements
- R1: Out of reset all three alarm outputs are 0 and `bit_ready` is 1. When `bit_valid` is 0, the data and marker pins have no effect on any detector.
- R2: Accepted bits are counted in back-to-back windows of 4632 bits, starting from the first accepted bit after reset. At the end of a window, `ais_alarm` becomes 1 if the window held 5 or fewer zeros.
- R3: At the end of a window that held 6 or more zeros, `ais_alarm` becomes 0. `ais_alarm` never changes inside a window.
- R4: `rlos_alarm` becomes 1 on the accepted bit that completes a run of 192 consecutive zeros. A shorter run has no effect.
- R5: While `rlos_alarm` is 1, the first accepted one opens a 112-bit window, and that one is position 1. The alarm clears on the bit that brings the window's count of ones to 14. If the window ends with fewer ones, the next one opens a new window.
- R6: The yellow source is selected as follows. With `esf_mode`=1 the FDL detector drives `rai_alarm`. With `esf_mode`=0, `yel_fbit`=0 selects the bit-2 detector and `yel_fbit`=1 selects the 12th-F-bit detector. Each detector keeps its own state, and the output follows the selection at once.
- R7: Bit-2 samples (`mark_b2`=1) are evaluated in consecutive blocks of 256. At a block end, the bit-2 detector sets if 254 or more samples were zero and clears otherwise. It does not change mid-block.
- R8: The 12th-F-bit detector (`mark_f12`=1) sets when two consecutive marked bits are 1 and clears when two consecutive marked bits are 0.
- R9: FDL bits (`mark_fdl`=1) are grouped into consecutive non-overlapping 16-bit words counted from reset. The first bit received is the word's MSB. A word matches the yellow pattern when it equals 16'h00FF.
- R10: FDL words are evaluated in consecutive blocks of 16. At a block end, the FDL detector sets if all 16 words matched, clears if 14 or fewer matched, and holds if exactly 15 matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | A received bit is present |
| bit_ready | output | 1 | Always 1; the block never stalls the stream |
| bit_data | input | 1 | Received bit value |
| mark_b2 | input | 1 | This bit is bit 2 of a channel |
| mark_f12 | input | 1 | This bit is the F-bit of the 12th frame |
| mark_fdl | input | 1 | This bit is an FDL bit |
| esf_mode | input | 1 | 1 = ESF framing, 0 = D4 framing |
| yel_fbit | input | 1 | D4 yellow mode: 0 = bit-2, 1 = 12th F-bit |
| ais_alarm | output | 1 | Blue alarm status |
| rai_alarm | output | 1 | Yellow alarm status |
| rlos_alarm | output | 1 | Red alarm (loss of signal) status |

## Verification
The hardest situations to reach from the ports are the exact thresholds. These are 5 against 6 zeros in an AIS window, and a loss-of-signal window that closes with 13 ones before a fresh window reaches 14. Both depend on window boundaries that the ports never show. The stimulus therefore reaches them by phase. AIS is exercised first, in whole 4632-bit windows counted from reset. The loss-of-signal clear is then driven with ones placed at known positions after the first one. Bit-2 and FDL samples are interleaved with unmarked ones, so the bit-2 and FDL blocks cannot trip the zero-run detector by accident.

// File: rtl/t1ad_pkg.sv
package t1ad_pkg;

  typedef enum logic [1:0] {
    YSRC_BIT2 = 2'd0,
    YSRC_FBIT = 2'd1,
    YSRC_FDL  = 2'd2
  } ysrc_e;

  localparam int          FDL_WBITS   = 16;
  localparam logic [15:0] FDL_YEL_PAT = 16'h00FF;

  function automatic ysrc_e pick_ysrc(input logic esf, input logic fbit_sel);
    if (esf)           return YSRC_FDL;
    else if (fbit_sel) return YSRC_FBIT;
    else               return YSRC_BIT2;
  endfunction

endpackage

// File: rtl/t1ad_block_vote.sv
// Counts hits over fixed blocks of ITEMS samples and decides at block end.
module t1ad_block_vote #(
  parameter int ITEMS   = 256,
  parameter int SET_MIN = 254,
  parameter int CLR_MAX = 253
) (
  input  logic clk,
  input  logic rst_n,
  input  logic item_valid,
  input  logic item_hit,
  output logic status
);
  localparam int CW = $clog2(ITEMS + 1);

  logic [CW-1:0] pos_q;
  logic [CW-1:0] hits_q;
  logic [CW-1:0] hits_now;
  logic          at_end;

  assign at_end   = (pos_q == CW'(ITEMS - 1));
  assign hits_now = hits_q + {{(CW-1){1'b0}}, item_hit};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      hits_q <= '0;
      status <= 1'b0;
    end else if (item_valid) begin
      if (at_end) begin
        pos_q  <= '0;
        hits_q <= '0;
        if (hits_now >= CW'(SET_MIN))      status <= 1'b1;
        else if (hits_now <= CW'(CLR_MAX)) status <= 1'b0;
      end else begin
        pos_q  <= pos_q + CW'(1);
        hits_q <= hits_now;
      end
    end
  end

  // R3 / R7 / R10: the decision only moves on the last sample of a block
  a_r3_hold_inside_block: assert property (@(posedge clk) disable iff (!rst_n)
    !(item_valid && at_end) |=> $stable(status));

  a_r2_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < CW'(ITEMS));

endmodule

// File: rtl/t1ad_rlos_det.sv
module t1ad_rlos_det #(
  parameter int ZRUN = 192,
  parameter int WIN  = 112,
  parameter int ONES = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic bit_i,
  output logic alarm_o
);
  localparam int ZW = $clog2(ZRUN + 1);
  localparam int PW = $clog2(WIN + 1);
  localparam int OW = $clog2(ONES + 1);

  logic [ZW-1:0] zrun_q;
  logic [PW-1:0] pos_q, pos_nx;
  logic [OW-1:0] ones_q, ones_nx;
  logic          track_q;
  logic          alarm_q;

  assign pos_nx  = pos_q + PW'(1);
  assign ones_nx = ones_q + {{(OW-1){1'b0}}, bit_i};
  assign alarm_o = alarm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zrun_q  <= '0;
      pos_q   <= '0;
      ones_q  <= '0;
      track_q <= 1'b0;
      alarm_q <= 1'b0;
    end else if (acc_i) begin
      if (!bit_i) begin
        if (zrun_q != ZW'(ZRUN)) zrun_q <= zrun_q + ZW'(1);
      end else begin
        zrun_q <= '0;
      end

      if (!alarm_q) begin
        track_q <= 1'b0;
        if (!bit_i && zrun_q == ZW'(ZRUN - 1)) alarm_q <= 1'b1;
      end else if (track_q) begin
        if (ones_nx == OW'(ONES)) begin
          alarm_q <= 1'b0;
          track_q <= 1'b0;
        end else if (pos_nx == PW'(WIN)) begin
          track_q <= 1'b0;
        end else begin
          pos_q  <= pos_nx;
          ones_q <= ones_nx;
        end
      end else if (bit_i) begin
        track_q <= 1'b1;
        pos_q   <= PW'(1);
        ones_q  <= OW'(1);
      end
    end
  end

  // R4: the alarm can only rise on an accepted zero
  a_r4_rise_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_q) |-> $past(acc_i && !bit_i));

  // R5: the alarm can only fall on an accepted one
  a_r5_fall_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm_q) |-> $past(acc_i && bit_i));

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> $stable(alarm_q));

endmodule

// File: rtl/t1ad_fdl_word.sv
// Gathers marked FDL bits, MSB first, into non-overlapping words.
module t1ad_fdl_word #(
  parameter int WBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic             bit_i,
  output logic             done_o,
  output logic [WBITS-1:0] word_o
);
  localparam int CW = $clog2(WBITS);

  logic [WBITS-1:0] sh_q;
  logic [CW-1:0]    cnt_q;

  assign word_o = {sh_q[WBITS-2:0], bit_i};
  assign done_o = take_i && (cnt_q == CW'(WBITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      sh_q  <= word_o;
      cnt_q <= done_o ? '0 : cnt_q + CW'(1);
    end
  end

  // R9: the count does not move without a marked FDL bit
  a_r9_count_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(cnt_q));

endmodule

// File: rtl/t1ad_rai_det.sv
module t1ad_rai_det
  import t1ad_pkg::*;
#(
  parameter int B2_ITEMS    = 256,
  parameter int B2_SET_MIN  = 254,
  parameter int FBIT_RUN    = 2,
  parameter int FDL_WORDS   = 16,
  parameter int FDL_CLR_MAX = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic bit_i,
  input  logic mark_b2_i,
  input  logic mark_f12_i,
  input  logic mark_fdl_i,
  input  logic esf_i,
  input  logic fbit_sel_i,
  output logic rai_o
);
  localparam int RW = $clog2(FBIT_RUN + 1);

  // bit-2 detector
  logic b2_st;
  t1ad_block_vote #(
    .ITEMS  (B2_ITEMS),
    .SET_MIN(B2_SET_MIN),
    .CLR_MAX(B2_SET_MIN - 1)
  ) u_b2 (
    .clk       (clk),
    .rst_n     (rst_n),
    .item_valid(acc_i && mark_b2_i),
    .item_hit  (!bit_i),
    .status    (b2_st)
  );

  // FDL pattern detector
  logic                 w_done;
  logic [FDL_WBITS-1:0] w_data;
  logic                 esf_st;

  t1ad_fdl_word #(.WBITS(FDL_WBITS)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .take_i(acc_i && mark_fdl_i),
    .bit_i (bit_i),
    .done_o(w_done),
    .word_o(w_data)
  );

  t1ad_block_vote #(
    .ITEMS  (FDL_WORDS),
    .SET_MIN(FDL_WORDS),
    .CLR_MAX(FDL_CLR_MAX)
  ) u_fdl (
    .clk       (clk),
    .rst_n     (rst_n),
    .item_valid(w_done),
    .item_hit  (w_data == FDL_YEL_PAT),
    .status    (esf_st)
  );

  // 12th-frame F-bit detector: run of equal marked values
  logic          f_take;
  logic [RW-1:0] run_q, run_nx;
  logic          last_q;
  logic          fbit_q;

  assign f_take = acc_i && mark_f12_i;

  always_comb begin
    if (run_q != '0 && bit_i == last_q)
      run_nx = (run_q == RW'(FBIT_RUN)) ? run_q : run_q + RW'(1);
    else
      run_nx = RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
      fbit_q <= 1'b0;
    end else if (f_take) begin
      run_q  <= run_nx;
      last_q <= bit_i;
      if (run_nx == RW'(FBIT_RUN)) fbit_q <= bit_i;
    end
  end

  // source select
  ysrc_e sel;
  assign sel = pick_ysrc(esf_i, fbit_sel_i);

  always_comb begin
    case (sel)
      YSRC_FDL:  rai_o = esf_st;
      YSRC_FBIT: rai_o = fbit_q;
      default:   rai_o = b2_st;
    endcase
  end

  // R8: the F-bit state only moves on a marked bit
  a_r8_change_needs_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !f_take |=> $stable(fbit_q));

  // R8: a rise needs this marked one and the previous marked value to be one
  a_r8_rise_after_two_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fbit_q) |-> $past(bit_i && last_q));

endmodule

// File: rtl/t1_rx_alarm_det.sv
module t1_rx_alarm_det #(
  parameter int AIS_WIN     = 4632,
  parameter int AIS_ZMAX    = 5,
  parameter int RLOS_ZRUN   = 192,
  parameter int RLOS_WIN    = 112,
  parameter int RLOS_ONES   = 14,
  parameter int B2_ITEMS    = 256,
  parameter int B2_SET_MIN  = 254,
  parameter int FBIT_RUN    = 2,
  parameter int FDL_WORDS   = 16,
  parameter int FDL_CLR_MAX = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_data,
  input  logic mark_b2,
  input  logic mark_f12,
  input  logic mark_fdl,
  input  logic esf_mode,
  input  logic yel_fbit,
  output logic ais_alarm,
  output logic rai_alarm,
  output logic rlos_alarm
);
  // AIS counts ones; "few zeros" equals "many ones"
  localparam int AIS_SET_ONES = AIS_WIN - AIS_ZMAX;
  localparam int AIS_CLR_ONES = AIS_WIN - AIS_ZMAX - 1;

  logic acc;
  assign bit_ready = 1'b1;
  assign acc       = bit_valid;

  t1ad_block_vote #(
    .ITEMS  (AIS_WIN),
    .SET_MIN(AIS_SET_ONES),
    .CLR_MAX(AIS_CLR_ONES)
  ) u_ais (
    .clk       (clk),
    .rst_n     (rst_n),
    .item_valid(acc),
    .item_hit  (bit_data),
    .status    (ais_alarm)
  );

  t1ad_rlos_det #(
    .ZRUN(RLOS_ZRUN),
    .WIN (RLOS_WIN),
    .ONES(RLOS_ONES)
  ) u_rlos (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_i  (acc),
    .bit_i  (bit_data),
    .alarm_o(rlos_alarm)
  );

  t1ad_rai_det #(
    .B2_ITEMS   (B2_ITEMS),
    .B2_SET_MIN (B2_SET_MIN),
    .FBIT_RUN   (FBIT_RUN),
    .FDL_WORDS  (FDL_WORDS),
    .FDL_CLR_MAX(FDL_CLR_MAX)
  ) u_rai (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_i     (acc),
    .bit_i     (bit_data),
    .mark_b2_i (mark_b2),
    .mark_f12_i(mark_f12),
    .mark_fdl_i(mark_fdl),
    .esf_i     (esf_mode),
    .fbit_sel_i(yel_fbit),
    .rai_o     (rai_alarm)
  );

  // R1: with no accepted bit, AIS and RLOS status hold
  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(ais_alarm) && $stable(rlos_alarm)));

endmodule

// File: tb/sim_t1_rx_alarm_det.sv
module sim_t1_rx_alarm_det;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic mark_b2 = 1'b0, mark_f12 = 1'b0, mark_fdl = 1'b0;
  logic esf_mode = 1'b0, yel_fbit = 1'b0;
  logic bit_ready, ais_alarm, rai_alarm, rlos_alarm;

  always #5 clk = ~clk;

  t1_rx_alarm_det u0 (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .mark_b2(mark_b2), .mark_f12(mark_f12), .mark_fdl(mark_fdl),
    .esf_mode(esf_mode), .yel_fbit(yel_fbit),
    .ais_alarm(ais_alarm), .rai_alarm(rai_alarm), .rlos_alarm(rlos_alarm));

  int vectors = 0, misses = 0;
  bit finished = 1'b0;

  // behavioural reference model
  int m_apos, m_az, m_zrun, m_wpos, m_wones, m_bpos, m_bz, m_fprev, m_fcnt, m_ew, m_em;
  bit m_ais, m_rlos, m_track, m_rb2, m_rf, m_re;
  logic [15:0] m_fw;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_apos = 0; m_az = 0; m_zrun = 0; m_wpos = 0; m_wones = 0;
      m_bpos = 0; m_bz = 0; m_fprev = -1; m_fcnt = 0; m_ew = 0; m_em = 0;
      m_ais = 0; m_rlos = 0; m_track = 0; m_rb2 = 0; m_rf = 0; m_re = 0; m_fw = '0;
    end else if (bit_valid) begin
      m_apos++; if (!bit_data) m_az++;
      if (m_apos == 4632) begin
        if (m_az <= 5) m_ais = 1; else m_ais = 0;
        m_apos = 0; m_az = 0;
      end
      if (bit_data) m_zrun = 0; else m_zrun++;
      if (!m_rlos) begin
        m_track = 0;
        if (m_zrun == 192) m_rlos = 1;
      end else if (m_track) begin
        m_wpos++; m_wones += int'(bit_data);
        if (m_wones == 14) begin m_rlos = 0; m_track = 0; end
        else if (m_wpos == 112) m_track = 0;
      end else if (bit_data) begin
        m_track = 1; m_wpos = 1; m_wones = 1;
      end
      if (mark_b2) begin
        m_bpos++; if (!bit_data) m_bz++;
        if (m_bpos == 256) begin m_rb2 = (m_bz >= 254); m_bpos = 0; m_bz = 0; end
      end
      if (mark_f12) begin
        if (m_fprev == int'(bit_data)) m_rf = bit_data;
        m_fprev = int'(bit_data);
      end
      if (mark_fdl) begin
        m_fw = {m_fw[14:0], bit_data}; m_fcnt++;
        if (m_fcnt == 16) begin
          m_fcnt = 0; m_ew++;
          if (m_fw == 16'h00FF) m_em++;
          if (m_ew == 16) begin
            if (m_em == 16) m_re = 1; else if (m_em <= 14) m_re = 0;
            m_ew = 0; m_em = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %0b expected %0b", tag, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2/R3 ais vs model", ais_alarm, m_ais);
      chk("R4/R5 rlos vs model", rlos_alarm, m_rlos);
      chk("R6 rai vs model", rai_alarm,
          esf_mode ? m_re : (yel_fbit ? m_rf : m_rb2));
      chk("R1 ready", bit_ready, 1'b1);
    end
  end

  task automatic drive(input logic b, input logic m2, input logic mf, input logic md);
    @(posedge clk); #2;
    bit_valid = 1'b1; bit_data = b; mark_b2 = m2; mark_f12 = mf; mark_fdl = md;
  endtask

  task automatic settle();
    @(posedge clk); #2;
    bit_valid = 1'b0; bit_data = 1'b0; mark_b2 = 1'b0; mark_f12 = 1'b0; mark_fdl = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_mode(input logic e, input logic f);
    @(posedge clk); #2; esf_mode = e; yel_fbit = f;
    @(negedge clk);
  endtask

  task automatic ais_window(input int nz);
    for (int i = 0; i < 4632; i++) drive(!((i % 700) == 0 && (i / 700) < nz), 0, 0, 0);
    settle();
  endtask

  task automatic b2s(input logic b);
    drive(b, 1, 0, 0);
    drive(1, 0, 0, 0);
  endtask

  task automatic fword(input logic [15:0] w);
    for (int j = 15; j >= 0; j--) begin
      drive(w[j], 0, 0, 1);
      drive(1, 0, 0, 0);
    end
  endtask

  task automatic fblock(input int ngood, input logic [15:0] bad);
    for (int k = 0; k < 16; k++) fword(k < ngood ? 16'h00FF : bad);
    settle();
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ais", ais_alarm, 1'b0);
    chk("R1 reset rlos", rlos_alarm, 1'b0);
    chk("R1 reset rai", rai_alarm, 1'b0);
    chk("R1 ready high", bit_ready, 1'b1);

    // R1: markers and zeros with no valid strobe
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #2;
      bit_valid = 1'b0; bit_data = 1'b0; mark_b2 = 1'b1; mark_f12 = 1'b1; mark_fdl = 1'b1;
    end
    settle();
    chk("R1 idle rlos", rlos_alarm, 1'b0);
    chk("R1 idle rai", rai_alarm, 1'b0);

    // AIS windows aligned from reset
    ais_window(0); chk("R2 all ones sets", ais_alarm, 1'b1);
    ais_window(5); chk("R2 five zeros keeps", ais_alarm, 1'b1);
    ais_window(6); chk("R3 six zeros clears", ais_alarm, 1'b0);
    for (int i = 0; i < 2316; i++) drive(1, 0, 0, 0);
    settle(); chk("R3 no change mid window", ais_alarm, 1'b0);
    for (int i = 0; i < 2316; i++) drive(1, 0, 0, 0);
    settle(); chk("R2 window end sets", ais_alarm, 1'b1);
    ais_window(6); chk("R3 clears again", ais_alarm, 1'b0);
    chk("R4 isolated zeros no rlos", rlos_alarm, 1'b0);

    // RLOS
    for (int i = 0; i < 191; i++) drive(0, 0, 0, 0);
    drive(1, 0, 0, 0); settle();
    chk("R4 191 zeros no set", rlos_alarm, 1'b0);
    for (int i = 0; i < 191; i++) drive(0, 0, 0, 0);
    settle(); chk("R4 still clear at 191", rlos_alarm, 1'b0);
    drive(0, 0, 0, 0); settle();
    chk("R4 set at 192", rlos_alarm, 1'b1);
    for (int k = 0; k < 13; k++) begin
      drive(1, 0, 0, 0);
      if (k < 12) for (int z = 0; z < 7; z++) drive(0, 0, 0, 0);
    end
    for (int z = 0; z < 15; z++) drive(0, 0, 0, 0);
    settle(); chk("R5 13 ones in window holds", rlos_alarm, 1'b1);
    for (int k = 0; k < 13; k++) drive(1, 0, 0, 0);
    settle(); chk("R5 new window 13 ones holds", rlos_alarm, 1'b1);
    drive(1, 0, 0, 0); settle();
    chk("R5 14th one clears", rlos_alarm, 1'b0);

    // bit-2 yellow
    for (int i = 0; i < 256; i++) b2s(i >= 254);
    settle(); chk("R7 254 zeros sets", rai_alarm, 1'b1);
    for (int i = 0; i < 100; i++) b2s(1);
    settle(); chk("R7 holds mid block", rai_alarm, 1'b1);
    for (int i = 0; i < 156; i++) b2s(1);
    settle(); chk("R7 ones block clears", rai_alarm, 1'b0);
    for (int i = 0; i < 256; i++) b2s(i >= 253);
    settle(); chk("R7 253 zeros stays clear", rai_alarm, 1'b0);
    for (int i = 0; i < 256; i++) b2s(i >= 254);
    settle(); chk("R7 254 zeros sets again", rai_alarm, 1'b1);
    set_mode(0, 1); chk("R6 select fbit detector", rai_alarm, 1'b0);
    set_mode(0, 0); chk("R6 select bit2 detector", rai_alarm, 1'b1);

    // 12th F-bit yellow
    set_mode(0, 1);
    drive(1, 0, 1, 0); settle(); chk("R8 single one no set", rai_alarm, 1'b0);
    drive(1, 0, 1, 0); settle(); chk("R8 two ones set", rai_alarm, 1'b1);
    drive(0, 0, 1, 0); settle(); chk("R8 single zero holds", rai_alarm, 1'b1);
    drive(1, 0, 1, 0); settle(); chk("R8 alternating holds", rai_alarm, 1'b1);
    drive(0, 0, 1, 0); settle(); chk("R8 one zero holds", rai_alarm, 1'b1);
    drive(0, 0, 1, 0); settle(); chk("R8 two zeros clear", rai_alarm, 1'b0);

    // ESF FDL yellow
    set_mode(1, 0); chk("R6 select fdl detector", rai_alarm, 1'b0);
    fblock(16, 16'h00FF); chk("R10 16 matches set", rai_alarm, 1'b1);
    fblock(15, 16'h00FE); chk("R10 15 matches hold", rai_alarm, 1'b1);
    fblock(14, 16'h00FE); chk("R10 14 matches clear", rai_alarm, 1'b0);
    for (int k = 0; k < 15; k++) fword(16'h00FF);
    settle(); chk("R10 no change mid block", rai_alarm, 1'b0);
    fword(16'h00FF); settle(); chk("R10 block end sets", rai_alarm, 1'b1);
    fblock(0, 16'hFF00); chk("R9 reversed order no match", rai_alarm, 1'b0);
    set_mode(0, 0); chk("R6 bit2 state kept", rai_alarm, 1'b1);

    // mixed traffic, checked every cycle against the model
    for (int seg = 0; seg < 60; seg++) begin
      int d;
      d = int'($urandom % 4);
      set_mode(1'($urandom), 1'($urandom));
      for (int i = 0; i < 500; i++) begin
        @(posedge clk); #2;
        bit_valid = ($urandom % 5) != 0;
        case (d)
          0: bit_data = 1'b0;
          1: bit_data = 1'($urandom);
          2: bit_data = ($urandom % 1000) != 0;
          default: bit_data = 1'b1;
        endcase
        mark_b2  = ($urandom % 3) == 0;
        mark_f12 = ($urandom % 7) == 0;
        mark_fdl = ($urandom % 4) == 0;
      end
    end
    settle();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      misses++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule